// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank

This block holds a group of 32-bit control words for a peripheral and serves them over a simple single-cycle memory-mapped bus. The bus has a select strobe, a write flag, a byte address, write data, read data and an error flag. Every stored word is driven out continuously on a flat vector, for the peripheral logic that uses the bits.

A register can be marked alias-capable. It then occupies a 16-byte window. The first word of the window is a plain read/write word. The other three words apply the write data as a mask: they set, clear or invert the stored bits, in one bus write and with no read-modify-write sequence. A register without aliases answers only at its own word.

Each register also carries read and write permission flags. The bank holds a configurable number of standalone registers plus one indexed array. Array element i sits at the array base plus i times a fixed stride. Accesses that break a permission, and accesses that hit no register, raise a one-cycle error flag and have no effect.

Top module: `sct_reg_bank`

## Requirements
- R1: A legal write to the window's word 0 (address bits [3:2] = 00) of an alias-capable register, or to the single word of a register without aliases, replaces the stored value with the write data.
- R2: A legal write to word 1 of an alias-capable window (address bits [3:2] = 01) sets the stored bits where the write data is 1 and leaves the other bits unchanged.
- R3: A legal write to word 2 of an alias-capable window (address bits [3:2] = 10) clears the stored bits where the write data is 1.
- R4: A legal write to word 3 of an alias-capable window (address bits [3:2] = 11) inverts the stored bits where the write data is 1.
- R5: For a register without aliases, the three words that follow its address do not decode to it. An access there flags an error and changes no register.
- R6: A write to a register without write permission, or a read of a register without read permission, is illegal. It raises the error flag, changes no register, and its read data is zero.
- R7: Indexed array element i responds at array base + i*stride, with its own set, clear and toggle words at +4, +8 and +0xC.
- R8: An access to an address that maps to no register makes bus_err high for exactly one cycle, the cycle after the strobe. It changes no register and returns zero read data. bus_err is low in every cycle that does not follow a strobe.
- R9: A legal read at any of the four words of an alias-capable register returns the current stored value. Read data is valid in the cycle after the strobe and is zero in every cycle that does not follow a legal read. Reads and idle cycles change no register.
- R10: An alias write takes effect at the clock edge that samples the strobe, so alias writes to one register on consecutive cycles compose in order.
- R11: While rst_n is low at a clock edge, every register loads its own reset value parameter, and bus_err and bus_rdata go to zero.
- R12: Address bits [1:0] are ignored in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data, or the bit mask for alias words |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after the strobe |
| bus_err | output | 1 | One-cycle error flag for an illegal or unmapped access |
| ctrl_q | output | (NUM_SGL+ARR_LEN)*DATA_W | All stored words; standalone registers first, then array elements, register k in bits [k*DATA_W +: DATA_W] |

## Verification
The bench builds the bank with a 10-bit address, four standalone registers and a four-element array at 0x100 with stride 0x20. The standalone registers are read/write with aliases at 0x000, read-only with aliases at 0x010, read/write without aliases at 0x020, and write-only with aliases at 0x030. With this configuration a single run reaches every alias operation, both kinds of permission violation, the undecoded alias words of a register without aliases, and the unmapped gaps between array elements. Because every stored word is visible on ctrl_q, the bench also shows directly that illegal writes, such as writes to the read-only register, leave it untouched.

// File: rtl/sct_pkg.sv
// Package: shared types of the set/clear/toggle register bank.
// Assumes nothing beyond a two-bit word index inside each alias window.
package sct_pkg;

    // Operation selected by address bits [3:2] inside an alias window.
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } sct_op_e;

    // Decode result of one register slot.
    typedef struct packed {
        logic    hit;
        sct_op_e op;
    } sct_hit_t;

endpackage

// File: rtl/sct_addr_match.sv
// Module: address matcher for one register slot.
// Compares the word address with the slot base. An alias-capable slot
// claims its whole 16-byte window and takes the operation from the word
// index; a plain slot claims only its own word.
// Assumes the base of an alias-capable slot is 16-byte aligned.
module sct_addr_match
    import sct_pkg::*;
#(
    parameter int               ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE     = '0,
    parameter bit               HAS_ALIAS = 1'b1
) (
    input  logic [ADDR_W-3:0] word_addr,
    output sct_hit_t          match
);

    generate
        if (HAS_ALIAS) begin : g_alias
            // Purpose: window compare, operation from the word index.
            always_comb begin
                match.hit = (word_addr[ADDR_W-3:2] == BASE[ADDR_W-1:4]);
                match.op  = sct_op_e'(word_addr[1:0]);
            end
        end else begin : g_plain
            // Purpose: exact word compare, always a plain write.
            always_comb begin
                match.hit = (word_addr == BASE[ADDR_W-1:2]);
                match.op  = OP_WRITE;
            end
        end
    endgenerate

endmodule

// File: rtl/sct_reg_cell.sv
// Module: one stored control word with its masked update.
// Applies write, set, clear or toggle at the clock edge when we is high.
// Assumes the caller has already gated we with decode and permission.
module sct_reg_cell
    import sct_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  sct_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] d;

    // Purpose: next value for each operation.
    always_comb begin
        unique case (op)
            OP_WRITE: d = wdata;
            OP_SET:   d = q | wdata;
            OP_CLR:   d = q & ~wdata;
            OP_TOG:   d = q ^ wdata;
            default:  d = q;
        endcase
    end

    // Purpose: storage with synchronous reset to the slot's reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sct_rd_mux.sv
// Module: AND-OR read multiplexer.
// Returns the OR of every value whose select bit is set.
// Assumes at most one select bit is high, so the OR equals a pick.
module sct_rd_mux #(
    parameter int N      = 8,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]        sel,
    input  logic [N*DATA_W-1:0] vals,
    output logic [DATA_W-1:0]   rdata
);

    // Purpose: fold the selected words into one read value.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            rdata = rdata | (vals[k*DATA_W +: DATA_W] & {DATA_W{sel[k]}});
        end
    end

endmodule

// File: rtl/sct_reg_bank.sv
// Module: set/clear/toggle register bank (top).
// Decodes a single-cycle bus into NUM_SGL standalone registers and one
// indexed array of ARR_LEN elements, checks read/write permission, and
// applies plain or masked writes in the strobe's clock edge. Read data and
// the error flag are registered and valid the cycle after the strobe.
// Assumes: register windows do not overlap, alias-capable bases and the
// array stride are multiples of 16 bytes, ADDR_W is at least 5.
module sct_reg_bank
    import sct_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int NUM_SGL = 4,
    parameter logic [NUM_SGL*ADDR_W-1:0] SGL_BASE =
        {10'h030, 10'h020, 10'h010, 10'h000},
    parameter logic [NUM_SGL-1:0] SGL_ALIAS = 4'b1011,
    parameter logic [NUM_SGL-1:0] SGL_RD    = 4'b0111,
    parameter logic [NUM_SGL-1:0] SGL_WR    = 4'b1101,
    parameter logic [NUM_SGL*DATA_W-1:0] SGL_RST =
        {32'h0000_00FF, 32'h1234_5678, 32'hCAFE_0001, 32'h0000_0000},
    parameter int               ARR_LEN    = 4,
    parameter logic [ADDR_W-1:0] ARR_BASE   = 10'h100,
    parameter logic [ADDR_W-1:0] ARR_STRIDE = 10'h020,
    parameter bit               ARR_ALIAS  = 1'b1,
    parameter bit               ARR_RD     = 1'b1,
    parameter bit               ARR_WR     = 1'b1,
    parameter logic [ARR_LEN*DATA_W-1:0] ARR_RST =
        {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000},
    localparam int NUM_REGS = NUM_SGL + ARR_LEN
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_err,
    output logic [NUM_REGS*DATA_W-1:0] ctrl_q
);

    logic [ADDR_W-3:0]   word_addr;
    logic                unused_byte_lane;
    sct_hit_t            match   [NUM_REGS];
    logic [NUM_REGS-1:0] hit;
    logic [NUM_REGS-1:0] rd_ok;
    logic [NUM_REGS-1:0] wr_ok;
    logic [NUM_REGS-1:0] we;
    logic [NUM_REGS-1:0] rd_sel;
    logic                allowed;
    logic [DATA_W-1:0]   rd_word;

    // Purpose: word address; the two byte-lane bits take no part in decode.
    assign word_addr        = bus_addr[ADDR_W-1:2];
    assign unused_byte_lane = ^bus_addr[1:0];

    // Standalone registers: base, alias and permissions per slot.
    for (genvar i = 0; i < NUM_SGL; i++) begin : g_sgl
        localparam logic [ADDR_W-1:0] BASE_I = SGL_BASE[i*ADDR_W +: ADDR_W];

        sct_addr_match #(
            .ADDR_W    (ADDR_W),
            .BASE      (BASE_I),
            .HAS_ALIAS (SGL_ALIAS[i])
        ) u_match (
            .word_addr (word_addr),
            .match     (match[i])
        );

        assign rd_ok[i] = SGL_RD[i];
        assign wr_ok[i] = SGL_WR[i];

        sct_reg_cell #(
            .DATA_W  (DATA_W),
            .RST_VAL (SGL_RST[i*DATA_W +: DATA_W])
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[i]),
            .op    (match[i].op),
            .wdata (bus_wdata),
            .q     (ctrl_q[i*DATA_W +: DATA_W])
        );
    end

    // Indexed array: element j placed at base plus j strides.
    for (genvar j = 0; j < ARR_LEN; j++) begin : g_arr
        localparam int               K      = NUM_SGL + j;
        localparam logic [ADDR_W-1:0] BASE_J = ADDR_W'(ARR_BASE + j * ARR_STRIDE);

        sct_addr_match #(
            .ADDR_W    (ADDR_W),
            .BASE      (BASE_J),
            .HAS_ALIAS (ARR_ALIAS)
        ) u_match (
            .word_addr (word_addr),
            .match     (match[K])
        );

        assign rd_ok[K] = ARR_RD;
        assign wr_ok[K] = ARR_WR;

        sct_reg_cell #(
            .DATA_W  (DATA_W),
            .RST_VAL (ARR_RST[j*DATA_W +: DATA_W])
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[K]),
            .op    (match[K].op),
            .wdata (bus_wdata),
            .q     (ctrl_q[K*DATA_W +: DATA_W])
        );
    end

    // Purpose: gather slot hits into one vector.
    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) begin
            hit[k] = match[k].hit;
        end
    end

    // Purpose: permission-qualified write enables and read selects.
    always_comb begin
        we      = {NUM_REGS{bus_sel & bus_wr}} & hit & wr_ok;
        rd_sel  = {NUM_REGS{bus_sel & ~bus_wr}} & hit & rd_ok;
        allowed = |(hit & (bus_wr ? wr_ok : rd_ok));
    end

    sct_rd_mux #(
        .N      (NUM_REGS),
        .DATA_W (DATA_W)
    ) u_rd_mux (
        .sel   (rd_sel),
        .vals  (ctrl_q),
        .rdata (rd_word)
    );

    // Purpose: register read data and the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_word;
            bus_err   <= bus_sel & ~allowed;
        end
    end

endmodule

// File: rtl/sct_reg_bank_chk.sv
// Module: property checker for sct_reg_bank, bound to every instance.
// Watches the bus and the stored words; the alias checks cover standalone
// register 0 when it is alias-capable and writable.
module sct_reg_bank_chk #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter logic [ADDR_W-1:0] R0_BASE = '0,
    parameter bit R0_ALIAS_WR = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       bus_err,
    input logic [NUM_REGS*DATA_W-1:0] ctrl_q
);

    localparam logic [ADDR_W-3:0] W0 = R0_BASE[ADDR_W-1:2];

    logic [ADDR_W-3:0] wa;
    logic              unused_chk;
    assign wa         = bus_addr[ADDR_W-1:2];
    assign unused_chk = ^bus_addr[1:0];

    // R8: no error without a strobe in the previous cycle
    p_err_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err);

    // R8: an errored access returns zero data
    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    // R6: an errored access leaves every register unchanged
    p_err_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(ctrl_q));

    // R9: reads and idle cycles change no register
    p_read_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || !bus_wr) |=> $stable(ctrl_q));

    // R9: read data is zero after a cycle with no strobe
    p_rdata_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == '0));

    generate
        if (R0_ALIAS_WR) begin : g_r0
            // R1: a plain write replaces register 0
            p_plain_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && wa == W0)
                |=> (ctrl_q[DATA_W-1:0] == $past(bus_wdata)));

            // R2: set word forces the mask bits high
            p_set_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && wa == W0 + (ADDR_W-2)'(1))
                |=> ((ctrl_q[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

            // R3: clear word forces the mask bits low
            p_clr_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && wa == W0 + (ADDR_W-2)'(2))
                |=> ((ctrl_q[DATA_W-1:0] & $past(bus_wdata)) == '0));

            // R4: toggle word inverts the mask bits
            p_tog_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && wa == W0 + (ADDR_W-2)'(3))
                |=> (ctrl_q[DATA_W-1:0] ==
                     ($past(ctrl_q[DATA_W-1:0]) ^ $past(bus_wdata))));
        end
    endgenerate

endmodule

bind sct_reg_bank sct_reg_bank_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_REGS    (NUM_REGS),
    .R0_BASE     (SGL_BASE[ADDR_W-1:0]),
    .R0_ALIAS_WR (SGL_ALIAS[0] & SGL_WR[0])
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_sct_reg_bank.sv
// Bench: directed corner cases, then seeded random accesses, against a
// model of the register map written from the requirements.
module tb_sct_reg_bank;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NR = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            bus_err;
    logic [NR*DW-1:0] ctrl_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] mdl [NR];

    always #4 clk = ~clk;

    sct_reg_bank #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .NUM_SGL    (4),
        .SGL_BASE   ({10'h030, 10'h020, 10'h010, 10'h000}),
        .SGL_ALIAS  (4'b1011),
        .SGL_RD     (4'b0111),
        .SGL_WR     (4'b1101),
        .SGL_RST    ({32'h0000_00FF, 32'h1234_5678, 32'hCAFE_0001, 32'h0000_0000}),
        .ARR_LEN    (4),
        .ARR_BASE   (10'h100),
        .ARR_STRIDE (10'h020),
        .ARR_ALIAS  (1'b1),
        .ARR_RD     (1'b1),
        .ARR_WR     (1'b1),
        .ARR_RST    ({32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000})
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ctrl_q    (ctrl_q)
    );

    // Register map of the configuration above.
    function automatic logic [AW-1:0] m_base(int k);
        if (k < 4) return AW'(k * 16);
        return AW'(10'h100 + (k - 4) * 32);
    endfunction
    function automatic bit m_alias(int k);
        return (k != 2);
    endfunction
    function automatic bit m_rd(int k);
        return (k != 3);
    endfunction
    function automatic bit m_wr(int k);
        return (k != 1);
    endfunction
    function automatic logic [DW-1:0] m_rst(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hCAFE_0001;
            2: return 32'h1234_5678;
            3: return 32'h0000_00FF;
            default: return 32'hA000_0000 | DW'(k - 4);
        endcase
    endfunction

    // Which register an address reaches (-1 for none) and the word index.
    function automatic int m_decode(logic [AW-1:0] a, output int op);
        op = 0;
        for (int k = 0; k < NR; k++) begin
            logic [AW-1:0] b;
            b = m_base(k);
            if (m_alias(k)) begin
                if (a[AW-1:4] == b[AW-1:4]) begin
                    op = int'(a[3:2]);
                    return k;
                end
            end else if (a[AW-1:2] == b[AW-1:2]) begin
                return k;
            end
        end
        return -1;
    endfunction

    // Requirement tag that a random access exercises.
    function automatic string m_tag(logic wr, logic [AW-1:0] a);
        int op;
        int k;
        k = m_decode(a, op);
        if (k < 0) return (a[AW-1:4] == 6'h02) ? "R5" : "R8";
        if (wr ? !m_wr(k) : !m_rd(k)) return "R6";
        if (!wr) return "R9";
        if (k >= 4) return "R7";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [NR*DW-1:0] m_pack();
        logic [NR*DW-1:0] v;
        for (int k = 0; k < NR; k++) v[k*DW +: DW] = mdl[k];
        return v;
    endfunction

    task automatic check(bit ok, string tag, string what,
                         logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One access: drive at a falling edge, check at the next falling edge.
    task automatic access(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        int op;
        int k;
        logic exp_err;
        logic [DW-1:0] exp_rd;
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        k = m_decode(a, op);
        exp_err = 1'b1;
        exp_rd  = '0;
        if (k >= 0 && (wr ? m_wr(k) : m_rd(k))) begin
            exp_err = 1'b0;
            if (!wr) begin
                exp_rd = mdl[k];
            end else begin
                case (op)
                    0: mdl[k] = d;
                    1: mdl[k] = mdl[k] | d;
                    2: mdl[k] = mdl[k] & ~d;
                    default: mdl[k] = mdl[k] ^ d;
                endcase
            end
        end
        check(bus_err == exp_err, tag, "bus_err", NR*DW'(bus_err), NR*DW'(exp_err));
        check(bus_rdata == exp_rd, tag, "bus_rdata", NR*DW'(bus_rdata), NR*DW'(exp_rd));
        check(ctrl_q == m_pack(), tag, "ctrl_q", ctrl_q, m_pack());
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5CE7_0001);
        for (int k = 0; k < NR; k++) mdl[k] = m_rst(k);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values, quiet bus outputs
        check(ctrl_q == m_pack(), "R11", "ctrl_q after reset", ctrl_q, m_pack());
        check(bus_err == 1'b0, "R11", "bus_err after reset", NR*DW'(bus_err), '0);
        check(bus_rdata == '0, "R11", "bus_rdata after reset", NR*DW'(bus_rdata), '0);

        // R1: plain write then read back
        access(1, 10'h000, 32'h5A5A_1234, "R1");
        access(0, 10'h000, 32'h0, "R1");
        // R2, R3, R4: masked alias writes on register 0
        access(1, 10'h004, 32'h0000_00F0, "R2");
        access(1, 10'h008, 32'h0000_1200, "R3");
        access(1, 10'h00C, 32'hFFFF_0000, "R4");
        // R9: reads at every alias word return the stored value
        access(0, 10'h004, 32'h0, "R9");
        access(0, 10'h008, 32'h0, "R9");
        access(0, 10'h00C, 32'h0, "R9");
        // R10: back-to-back alias writes compose
        access(1, 10'h000, 32'h0000_0000, "R10");
        access(1, 10'h004, 32'h0000_FFFF, "R10");
        access(1, 10'h008, 32'h0000_0F0F, "R10");
        access(1, 10'h00C, 32'h8000_0001, "R10");
        access(0, 10'h000, 32'h0, "R10");
        // R5: alias words of the register without aliases are not decoded
        access(1, 10'h024, 32'hFFFF_FFFF, "R5");
        access(1, 10'h02C, 32'hFFFF_FFFF, "R5");
        access(0, 10'h028, 32'h0, "R5");
        access(1, 10'h020, 32'h0BAD_F00D, "R5");
        // R6: read-only and write-only registers
        access(1, 10'h010, 32'h0000_0000, "R6");
        access(1, 10'h018, 32'hFFFF_FFFF, "R6");
        access(0, 10'h014, 32'h0, "R6");
        access(0, 10'h030, 32'h0, "R6");
        access(1, 10'h034, 32'hF000_0000, "R6");
        access(0, 10'h03C, 32'h0, "R6");
        // R7: array elements and their aliases
        access(1, 10'h140, 32'h1111_2222, "R7");
        access(1, 10'h164, 32'h0000_0F00, "R7");
        access(1, 10'h12C, 32'hA000_0001, "R7");
        access(0, 10'h148, 32'h0, "R7");
        access(0, 10'h160, 32'h0, "R7");
        // R8: unmapped addresses, including the gaps between elements
        access(1, 10'h110, 32'hFFFF_FFFF, "R8");
        access(0, 10'h200, 32'h0, "R8");
        access(1, 10'h3FC, 32'h1234_5678, "R8");
        access(0, 10'h050, 32'h0, "R8");
        // R12: byte-lane address bits are ignored
        access(1, 10'h003, 32'hCCCC_3333, "R12");
        access(1, 10'h006, 32'h0000_000C, "R12");
        access(0, 10'h00D, 32'h0, "R12");
        access(1, 10'h023, 32'h7777_0000, "R12");

        // Seeded random mix over mapped windows and arbitrary addresses.
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic          wr;
            if (($urandom % 10) < 8) begin
                a = m_base(int'($urandom % NR)) + AW'(($urandom % 4) * 4)
                    + AW'($urandom % 4);
            end else begin
                a = AW'($urandom);
            end
            wr = 1'($urandom);
            access(wr, a, $urandom, m_tag(wr, a));
            if (($urandom % 8) == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule